// File: doc/BRIEF.md
# Single-Precision Floating-Point Multiplier

This block multiplies two 32-bit single-precision floating-point operands. Each word has a sign bit [31], an 8-bit exponent field [30:23] stored with a bias of 127, and a 23-bit fraction [22:0] with an implied leading one. For a finite normal operand the value is (-1)^sign x 2^(exponent-127) x 1.fraction. The block decodes both operands and adds the biased exponents, removing one bias. It forms the 48-bit product of the two 24-bit significands and normalises it. It then rounds the result to 24 significant bits under one of four rounding modes, and sets the sign last. It also returns four exception flags.

Work is sequenced by a four-state machine. In ST_IDLE the block is ready; an operand pair presented with valid moves it to ST_MULT (IDLE->MULT). In ST_MULT the operands are decoded, the special cases are resolved and the significand product is registered (MULT->ROUND). In ST_ROUND the product is normalised and rounded, or the special result is chosen, into the output registers (ROUND->EMIT). In ST_EMIT the result is presented with out_valid for one cycle (EMIT->IDLE). Operands whose exponent field is zero are treated as zero (denormals are flushed). The block has no output back-pressure: a consumer must take the result in the cycle out_valid is high.

Top module: `spfp_mul`

## Requirements
- R1: For two finite normal operands in round-to-nearest-even mode (rmode 2'b00), the result is the exact product rounded to 24 significant bits, with ties going to the even significand. If the significand product is 2.0 or more, it is shifted right once and the exponent is raised by one.
- R2: Rounding mode encodings: 2'b01 truncates toward zero, 2'b10 rounds toward plus infinity and 2'b11 rounds toward minus infinity. Each mode is applied using the guard, round and sticky bits below the result LSB.
- R3: The sign of every non-NaN result is the XOR of the two operand signs, including zero and infinity results.
- R4: in_ready is high only in ST_IDLE. An operand pair accepted at a clock edge gives out_valid high for exactly one cycle, after the third following edge. Inputs presented while the block is busy are ignored and produce no extra result.
- R5: Any NaN operand (exponent field all ones, fraction nonzero) gives the quiet NaN 0x7FC00000. The invalid flag is raised when a NaN operand is signalling (fraction bit 22 clear).
- R6: Zero times infinity, in either order, gives 0x7FC00000 and raises the invalid flag.
- R7: Infinity (exponent all ones, fraction zero) times a nonzero finite value or an infinity gives an infinity of the XOR sign, with no flags raised.
- R8: An operand with exponent field zero (zero or denormal) times a finite value gives a zero of the XOR sign, with no flags raised.
- R9: If the biased exponent after rounding is 255 or more, the overflow and inexact flags are set. The result is infinity in nearest mode, in the mode rounding toward the result's sign side, and otherwise the largest finite magnitude (0x7F7FFFFF with the sign).
- R10: If the biased exponent after rounding is below 1, the result is a zero of the XOR sign, and the underflow and inexact flags are set.
- R11: For in-range finite results, inexact is set exactly when any bit of the exact product below the result LSB is nonzero.
- R12: When rounding carries out of the 24-bit significand, the result is renormalised to 1.0 and the exponent is raised by one.
- R13: While reset is applied and just after it, in_ready is 1, out_valid is 0, and result and flags read 0.
- Flag bit positions in flags_o: [3] invalid, [2] overflow, [1] underflow, [0] inexact.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| in_valid_i | input | 1 | Operand pair and mode are valid |
| in_ready_o | output | 1 | Block can accept an operand pair |
| opa_i | input | 32 | First operand |
| opb_i | input | 32 | Second operand |
| rmode_i | input | 2 | Rounding mode |
| out_valid_o | output | 1 | Result and flags valid this cycle |
| result_o | output | 32 | Rounded product |
| flags_o | output | 4 | Exception flags: invalid, overflow, underflow, inexact |

## Verification
Exact small products separate errors in exponent and bias handling from errors in rounding. Operands such as 1.1 and 1/3, of both signs, run in all four modes, and tell each mode's increment rule and its dependence on the sign apart. Products at the extremes of the exponent range check the mode-dependent overflow saturation and the flush to zero after rounding. A product just below 2.0, rounded upward, checks the carry renormalisation. Encoded NaNs, infinities, zeros and denormals in both operand orders check the priority between special cases, and a pseudo-random stream compares against a model in the bench that rounds by comparing the remainder with one half.

// File: rtl/spfp_pkg.sv
package spfp_pkg;

    typedef enum logic [1:0] {
        RM_NEAR_EVEN = 2'b00,
        RM_TO_ZERO   = 2'b01,
        RM_TO_POS    = 2'b10,
        RM_TO_NEG    = 2'b11
    } rnd_mode_e;

    typedef enum logic [1:0] {
        CL_ZERO,
        CL_NORM,
        CL_INF,
        CL_NAN
    } op_class_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_MULT,
        ST_ROUND,
        ST_EMIT
    } fsm_state_e;

    typedef struct packed {
        logic invalid;
        logic overflow;
        logic underflow;
        logic inexact;
    } exc_flags_t;

endpackage

// File: rtl/spfp_unpack.sv
module spfp_unpack
    import spfp_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23,
    localparam int WORD_W = 1 + EXP_W + FRAC_W
) (
    input  logic [WORD_W-1:0] word_i,
    output logic              sign_o,
    output logic [EXP_W-1:0]  exp_o,
    output logic [FRAC_W:0]   sig_o,
    output op_class_e         cls_o,
    output logic              snan_o
);

    logic [FRAC_W-1:0] frac;
    logic              exp_ones;
    logic              exp_zero;

    always_comb begin
        frac     = word_i[FRAC_W-1:0];
        exp_o    = word_i[WORD_W-2:FRAC_W];
        sign_o   = word_i[WORD_W-1];
        exp_ones = &exp_o;
        exp_zero = ~|exp_o;
        sig_o    = '0;
        snan_o   = 1'b0;
        if (exp_zero) begin
            cls_o = CL_ZERO;
        end else if (exp_ones) begin
            if (frac == '0) begin
                cls_o = CL_INF;
            end else begin
                cls_o  = CL_NAN;
                snan_o = ~frac[FRAC_W-1];
            end
        end else begin
            cls_o = CL_NORM;
            sig_o = {1'b1, frac};
        end
    end

endmodule

// File: rtl/spfp_round.sv
module spfp_round
    import spfp_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23,
    localparam int WORD_W = 1 + EXP_W + FRAC_W,
    localparam int SIG_W  = FRAC_W + 1,
    localparam int PROD_W = 2 * SIG_W,
    localparam int ESUM_W = EXP_W + 2
) (
    input  logic              sign_i,
    input  rnd_mode_e         mode_i,
    input  logic [PROD_W-1:0] prod_i,
    input  logic [ESUM_W-1:0] esum_i,
    output logic [WORD_W-1:0] word_o,
    output logic              ovf_o,
    output logic              unf_o,
    output logic              inx_o
);

    localparam int BIAS = (1 << (EXP_W - 1)) - 1;
    localparam int EMAX = (1 << EXP_W) - 1;

    logic              top;
    logic [PROD_W-1:0] norm;
    logic [SIG_W-1:0]  mant;
    logic              grd, rnd, stk, lost, incr, to_inf;
    logic [SIG_W:0]    sum;
    logic              carry;
    logic [FRAC_W-1:0] frac;
    logic [ESUM_W-1:0] ebig;
    logic [ESUM_W-1:0] eout;

    always_comb begin
        top  = prod_i[PROD_W-1];
        norm = top ? prod_i : (prod_i << 1);
        mant = norm[PROD_W-1 -: SIG_W];
        grd  = norm[SIG_W-1];
        rnd  = norm[SIG_W-2];
        stk  = |norm[SIG_W-3:0];
        lost = grd | rnd | stk;

        unique case (mode_i)
            RM_NEAR_EVEN: incr = grd & (rnd | stk | mant[0]);
            RM_TO_ZERO:   incr = 1'b0;
            RM_TO_POS:    incr = lost & ~sign_i;
            RM_TO_NEG:    incr = lost & sign_i;
            default:      incr = 1'b0;
        endcase

        unique case (mode_i)
            RM_NEAR_EVEN: to_inf = 1'b1;
            RM_TO_ZERO:   to_inf = 1'b0;
            RM_TO_POS:    to_inf = ~sign_i;
            RM_TO_NEG:    to_inf = sign_i;
            default:      to_inf = 1'b1;
        endcase

        sum   = {1'b0, mant} + {{SIG_W{1'b0}}, incr};
        carry = sum[SIG_W];
        frac  = carry ? '0 : sum[FRAC_W-1:0];
        ebig  = esum_i + {{(ESUM_W-1){1'b0}}, top} + {{(ESUM_W-1){1'b0}}, carry};
        eout  = ebig - ESUM_W'(BIAS);

        ovf_o = 1'b0;
        unf_o = 1'b0;
        inx_o = lost;
        if (ebig <= ESUM_W'(BIAS)) begin
            unf_o  = 1'b1;
            inx_o  = 1'b1;
            word_o = {sign_i, {(WORD_W-1){1'b0}}};
        end else if (ebig >= ESUM_W'(EMAX + BIAS)) begin
            ovf_o = 1'b1;
            inx_o = 1'b1;
            if (to_inf) begin
                word_o = {sign_i, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
            end else begin
                word_o = {sign_i, EXP_W'(EMAX - 1), {FRAC_W{1'b1}}};
            end
        end else begin
            word_o = {sign_i, eout[EXP_W-1:0], frac};
        end
    end

endmodule

// File: rtl/spfp_mul.sv
module spfp_mul
    import spfp_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23,
    localparam int WORD_W = 1 + EXP_W + FRAC_W,
    localparam int SIG_W  = FRAC_W + 1,
    localparam int PROD_W = 2 * SIG_W,
    localparam int ESUM_W = EXP_W + 2
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              in_valid_i,
    output logic              in_ready_o,
    input  logic [WORD_W-1:0] opa_i,
    input  logic [WORD_W-1:0] opb_i,
    input  logic [1:0]        rmode_i,
    output logic              out_valid_o,
    output logic [WORD_W-1:0] result_o,
    output logic [3:0]        flags_o
);

    localparam logic [WORD_W-1:0] QNAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};
    localparam int NOPS = 2;

    fsm_state_e state_q, state_d;

    logic [NOPS-1:0][WORD_W-1:0] ops_q;
    rnd_mode_e                   mode_q;

    logic             sgn_u  [NOPS];
    logic [EXP_W-1:0] exp_u  [NOPS];
    logic [FRAC_W:0]  sig_u  [NOPS];
    op_class_e        cls_u  [NOPS];
    logic             snan_u [NOPS];

    // Operand decoders, one per operand
    for (genvar g = 0; g < NOPS; g++) begin : g_unpack
        spfp_unpack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_unpack (
            .word_i (ops_q[g]),
            .sign_o (sgn_u[g]),
            .exp_o  (exp_u[g]),
            .sig_o  (sig_u[g]),
            .cls_o  (cls_u[g]),
            .snan_o (snan_u[g])
        );
    end

    // Special-case resolution in ST_MULT
    logic              res_sign;
    logic              any_nan, any_inf, any_zero, zero_inf;
    logic              spc_d;
    logic [WORD_W-1:0] spw_d;
    logic              spinv_d;
    logic [PROD_W-1:0] prod_d;
    logic [ESUM_W-1:0] esum_d;

    always_comb begin
        res_sign = sgn_u[0] ^ sgn_u[1];
        any_nan  = (cls_u[0] == CL_NAN)  || (cls_u[1] == CL_NAN);
        any_inf  = (cls_u[0] == CL_INF)  || (cls_u[1] == CL_INF);
        any_zero = (cls_u[0] == CL_ZERO) || (cls_u[1] == CL_ZERO);
        zero_inf = any_inf && any_zero;
        spc_d    = any_nan || any_inf || any_zero;
        spinv_d  = zero_inf || snan_u[0] || snan_u[1];
        if (any_nan || zero_inf) begin
            spw_d = QNAN;
        end else if (any_inf) begin
            spw_d = {res_sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
        end else begin
            spw_d = {res_sign, {(WORD_W-1){1'b0}}};
        end
        prod_d = PROD_W'(sig_u[0]) * PROD_W'(sig_u[1]);
        esum_d = ESUM_W'(exp_u[0]) + ESUM_W'(exp_u[1]);
    end

    // Stage registers between ST_MULT and ST_ROUND
    logic              spc_q, spinv_q, sign_q;
    logic [WORD_W-1:0] spw_q;
    logic [PROD_W-1:0] prod_q;
    logic [ESUM_W-1:0] esum_q;

    logic [WORD_W-1:0] rnd_word;
    logic              rnd_ovf, rnd_unf, rnd_inx;

    spfp_round #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_round (
        .sign_i (sign_q),
        .mode_i (mode_q),
        .prod_i (prod_q),
        .esum_i (esum_q),
        .word_o (rnd_word),
        .ovf_o  (rnd_ovf),
        .unf_o  (rnd_unf),
        .inx_o  (rnd_inx)
    );

    logic [WORD_W-1:0] res_q;
    exc_flags_t        flg_q;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (in_valid_i) state_d = ST_MULT;
            ST_MULT:  state_d = ST_ROUND;
            ST_ROUND: state_d = ST_EMIT;
            ST_EMIT:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Handshake outputs
    always_comb begin
        in_ready_o  = (state_q == ST_IDLE);
        out_valid_o = (state_q == ST_EMIT);
        result_o    = res_q;
        flags_o     = flg_q;
    end

    // Datapath registers
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            ops_q   <= '0;
            mode_q  <= RM_NEAR_EVEN;
            spc_q   <= 1'b0;
            spinv_q <= 1'b0;
            sign_q  <= 1'b0;
            spw_q   <= '0;
            prod_q  <= '0;
            esum_q  <= '0;
            res_q   <= '0;
            flg_q   <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (in_valid_i) begin
                        ops_q[0] <= opa_i;
                        ops_q[1] <= opb_i;
                        mode_q   <= rnd_mode_e'(rmode_i);
                    end
                end
                ST_MULT: begin
                    spc_q   <= spc_d;
                    spinv_q <= spinv_d;
                    spw_q   <= spw_d;
                    sign_q  <= res_sign;
                    prod_q  <= prod_d;
                    esum_q  <= esum_d;
                end
                ST_ROUND: begin
                    if (spc_q) begin
                        res_q <= spw_q;
                        flg_q <= '{invalid: spinv_q, overflow: 1'b0, underflow: 1'b0, inexact: 1'b0};
                    end else begin
                        res_q <= rnd_word;
                        flg_q <= '{invalid: 1'b0, overflow: rnd_ovf, underflow: rnd_unf, inexact: rnd_inx};
                    end
                end
                default: ;
            endcase
        end
    end

    // R4: busy and emit never overlap with readiness
    a_r4_ready_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
        out_valid_o |-> !in_ready_o);

    // R4: result is a single-cycle pulse
    a_r4_out_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
        out_valid_o |=> !out_valid_o);

    // R4: fixed latency from acceptance to result
    a_r4_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (in_valid_i && in_ready_o) |-> ##3 out_valid_o);

    // R3: non-NaN results carry the XOR of the accepted operand signs
    a_r3_sign_xor: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (out_valid_o && !((&result_o[WORD_W-2:FRAC_W]) && (result_o[FRAC_W-1:0] != '0)))
        |-> (result_o[WORD_W-1] == (ops_q[0][WORD_W-1] ^ ops_q[1][WORD_W-1])));

    // R6: invalid always comes with the quiet NaN and no other flag
    a_r6_invalid_nan: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (out_valid_o && flags_o[3]) |-> (result_o == QNAN && flags_o[2:0] == 3'b000));

    // R9: overflow always reports inexact and never underflow
    a_r9_ovf_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (out_valid_o && flags_o[2]) |-> (flags_o[0] && !flags_o[1]));

    // R10: underflow leaves a signed zero
    a_r10_unf_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (out_valid_o && flags_o[1]) |-> (result_o[WORD_W-2:0] == '0 && flags_o[0]));

endmodule

// File: tb/spfp_mul_tb_top.sv
module spfp_mul_tb_top;

    localparam int CLK_PERIOD_NS = 10;
    localparam logic [31:0] QNAN = 32'h7FC0_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] opa = '0, opb = '0;
    logic [1:0]  rmode = 2'b00;
    logic        out_valid;
    logic [31:0] result;
    logic [3:0]  flags;

    int n_checks = 0;
    int n_errors = 0;
    int n_sent   = 0;
    int n_seen   = 0;
    bit done     = 1'b0;

    logic [35:0] exp_q[$];
    string       tag_q[$];

    always #(CLK_PERIOD_NS / 2) clk = ~clk;

    spfp_mul dut_i (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .in_valid_i  (in_valid),
        .in_ready_o  (in_ready),
        .opa_i       (opa),
        .opb_i       (opb),
        .rmode_i     (rmode),
        .out_valid_o (out_valid),
        .result_o    (result),
        .flags_o     (flags)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] expv);
        n_checks++;
        if (act !== expv) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    // Bench model: rounds by comparing the discarded remainder with one half
    function automatic logic [35:0] ref_mul(input logic [31:0] a, input logic [31:0] b,
                                            input logic [1:0] rm);
        logic s;
        int ea, eb, k, sh, be;
        bit za, zb, ia, ib, na, nb, sa_n, sb_n, up, inf;
        longint unsigned p, m, rem, half;
        s  = a[31] ^ b[31];
        ea = int'(a[30:23]);
        eb = int'(b[30:23]);
        za = (ea == 0);
        zb = (eb == 0);
        ia = (ea == 255) && (a[22:0] == 0);
        ib = (eb == 255) && (b[22:0] == 0);
        na = (ea == 255) && (a[22:0] != 0);
        nb = (eb == 255) && (b[22:0] != 0);
        sa_n = na && !a[22];
        sb_n = nb && !b[22];
        if (na || nb) return {((sa_n || sb_n) ? 4'b1000 : 4'b0000), QNAN};
        if ((za && ib) || (ia && zb)) return {4'b1000, QNAN};
        if (ia || ib) return {4'b0000, s, 8'hFF, 23'd0};
        if (za || zb) return {4'b0000, s, 31'd0};
        p    = longint'({1'b1, a[22:0]}) * longint'({1'b1, b[22:0]});
        k    = p[47] ? 47 : 46;
        sh   = k - 23;
        m    = p >> sh;
        rem  = p & ((64'd1 << sh) - 1);
        half = 64'd1 << (sh - 1);
        be   = ea + eb - 127 + (k - 46);
        case (rm)
            2'b00:   up = (rem > half) || ((rem == half) && ((m & 1) != 0));
            2'b01:   up = 1'b0;
            2'b10:   up = (rem != 0) && !s;
            default: up = (rem != 0) && s;
        endcase
        if (up) m = m + 1;
        if (m == (64'd1 << 24)) begin
            m  = m >> 1;
            be = be + 1;
        end
        if (be < 1) return {4'b0011, s, 31'd0};
        if (be > 254) begin
            inf = (rm == 2'b00) || (rm == 2'b10 && !s) || (rm == 2'b11 && s);
            return inf ? {4'b0101, s, 8'hFF, 23'd0} : {4'b0101, s, 8'hFE, 23'h7FFFFF};
        end
        return {3'b000, (rem != 0), s, be[7:0], m[22:0]};
    endfunction

    task automatic send(input logic [31:0] a, input logic [31:0] b, input logic [1:0] rm,
                        input string tag);
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        opa = a; opb = b; rmode = rm; in_valid = 1'b1;
        exp_q.push_back(ref_mul(a, b, rm));
        tag_q.push_back(tag);
        n_sent++;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // R4: keep valid high with other operands while busy; check timing and ignoring
    task automatic send_busy(input logic [31:0] a, input logic [31:0] b, input logic [1:0] rm);
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        opa = a; opb = b; rmode = rm; in_valid = 1'b1;
        exp_q.push_back(ref_mul(a, b, rm));
        tag_q.push_back("R4 busy-ignore result");
        n_sent++;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            opa = 32'h4120_0000 + 32'(i); opb = 32'hC2C8_0000; rmode = 2'(i);
            check("R4 in_ready low while busy", 64'(in_ready), 64'd0);
            check("R4 out_valid timing", 64'(out_valid), 64'(i == 2));
        end
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // Scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            n_seen++;
            if (exp_q.size() == 0) begin
                check("R4 unexpected result", 64'(result), 64'hFFFF_FFFF);
            end else begin
                logic [35:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check($sformatf("%s result", t), 64'(result), 64'(e[31:0]));
                check($sformatf("%s flags", t), 64'(flags), 64'(e[35:32]));
            end
        end
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] x;
        x = 32'h1234_5678;
        repeat (3) @(negedge clk);
        // R13: state during reset
        check("R13 in_ready in reset", 64'(in_ready), 64'd1);
        check("R13 out_valid in reset", 64'(out_valid), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R13 result after reset", 64'(result), 64'd0);
        check("R13 flags after reset", 64'(flags), 64'd0);
        check("R13 out_valid after reset", 64'(out_valid), 64'd0);

        // R1: exact products
        send(32'h3FC0_0000, 32'h4000_0000, 2'b00, "R1 1.5x2");
        send(32'h4040_0000, 32'h40A0_0000, 2'b00, "R1 3x5");
        send(32'h3F80_0000, 32'h3F80_0000, 2'b00, "R1 1x1");
        // R3: sign handling
        send(32'hBF40_0000, 32'h4080_0000, 2'b00, "R3 -0.75x4");
        send(32'hC000_0000, 32'hC040_0000, 2'b00, "R3 -2x-3");
        // R2 / R11: inexact operands under every mode, both signs
        for (int m = 0; m < 4; m++) begin
            send(32'h3F8C_CCCD, 32'h3F8C_CCCD, 2'(m), "R2 R11 1.1x1.1");
            send(32'hBF8C_CCCD, 32'h3F8C_CCCD, 2'(m), "R2 R11 -1.1x1.1");
            send(32'h3EAA_AAAB, 32'h4040_0000, 2'(m), "R2 R11 third x3");
            send(32'hBEAA_AAAB, 32'h3F8C_CCCD, 2'(m), "R2 -third x1.1");
        end
        // R12: product just below 2.0 rounded upward carries out
        send(32'h3FB5_04F3, 32'h3FB5_04F3, 2'b10, "R12 carry renorm");
        send(32'h3FB5_04F3, 32'h3FB5_04F3, 2'b00, "R12 no carry nearest");
        send(32'h3FFF_FFFF, 32'h3F7F_FFFF, 2'b10, "R12 all-ones up");
        // R9: overflow per mode
        for (int m = 0; m < 4; m++) begin
            send(32'h7F00_0000, 32'h4000_0000, 2'(m), "R9 +overflow");
            send(32'hFF00_0000, 32'h4000_0000, 2'(m), "R9 -overflow");
        end
        // R10: underflow and its boundary
        send(32'h0080_0000, 32'h3F00_0000, 2'b00, "R10 underflow +");
        send(32'h8080_0000, 32'h3F00_0000, 2'b10, "R10 underflow -");
        send(32'h0080_0000, 32'h3F80_0000, 2'b00, "R10 smallest normal kept");
        // R5: NaN inputs
        send(32'h7FC0_0001, 32'h3F80_0000, 2'b00, "R5 quiet NaN");
        send(32'h4000_0000, 32'hFF80_0001, 2'b01, "R5 signalling NaN");
        send(32'h7FC0_0000, 32'h0000_0000, 2'b00, "R5 NaN x zero");
        // R6: zero times infinity both orders
        send(32'h0000_0000, 32'hFF80_0000, 2'b00, "R6 zero x -inf");
        send(32'h7F80_0000, 32'h8000_0000, 2'b00, "R6 inf x -zero");
        send(32'h0000_0001, 32'h7F80_0000, 2'b00, "R6 denormal x inf");
        // R7: infinity results
        send(32'h7F80_0000, 32'hC000_0000, 2'b00, "R7 inf x -2");
        send(32'hFF80_0000, 32'hFF80_0000, 2'b11, "R7 -inf x -inf");
        // R8: zero and flushed denormal
        send(32'h8000_0000, 32'h4040_0000, 2'b00, "R8 -0 x 3");
        send(32'h0000_0001, 32'h4000_0000, 2'b00, "R8 denormal flushed");
        send(32'h4000_0000, 32'h807F_FFFF, 2'b10, "R8 x -denormal");
        // R4: busy inputs ignored, fixed latency
        send_busy(32'h4040_0000, 32'h3F00_0000, 2'b00);
        // R1 / R2: pseudo-random stream
        for (int i = 0; i < 48; i++) begin
            logic [31:0] a, b;
            x = x ^ (x << 13); x = x ^ (x >> 17); x = x ^ (x << 5);
            a = {x[31], 1'b0, x[29:0]} ^ 32'h4000_0000;
            x = x ^ (x << 13); x = x ^ (x >> 17); x = x ^ (x << 5);
            b = {x[31], x[7], ~x[7], x[28:0]};
            send(a, b, 2'(i % 4), "R1 R2 random");
        end

        repeat (10) @(negedge clk);
        check("R4 all results seen", 64'(exp_q.size()), 64'd0);
        check("R4 result count", 64'(n_seen), 64'(n_sent));
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

endmodule